// File: doc/BRIEF.md
# Pulse-Swallow Programmable RF Divider

This block divides a fast divider clock by a programmable 15-bit ratio using the pulse-swallow arrangement. A dual-modulus prescaler counts either nine or eight input clocks per prescaler cycle. A small swallow counter decides how many of those prescaler cycles use the longer modulus, and a wider main counter sets how many prescaler cycles make up one output period. The output period is therefore 8·M + A input clocks, where A is the swallow count and M is the main count.

The divided output is a one-clock pulse that drives a phase comparator. A square wave at half that rate is also provided for a test pin. A new ratio is presented as one complete 15-bit word with a load strobe. The word is held internally and the counters pick it up only when the current output period finishes, so a retune never produces a shortened period. A word below the smallest legal ratio is raised to that minimum, and an error flag records that this happened.

Top module: `pulse_swallow_div`

## Requirements
- R1: With a legal ratio word loaded, consecutive `fpdPulse` pulses are exactly 8·M + A clock edges apart. A is bits [2:0] of `ratioWord` and M is bits [14:3]. The legal range is 56 to 32767.
- R2: A word below 56 is applied as 56 and sets `ratioErr` to 1. A word of 56 or more sets `ratioErr` to 0.
- R3: `ratioErr` changes only on a clock edge where `ratioLoad` is high.
- R4: A word loaded while an output period is running leaves that period's length unchanged. The new ratio governs every period from the next one on.
- R5: If several words are loaded within one output period, only the last one takes effect.
- R6: `fpdPulse` is high for exactly one clock per output period.
- R7: `fpdHalf` toggles on the same edge that raises `fpdPulse` and holds its value on every other edge.
- R8: A synchronous reset (`rst` high at a clock edge) does the following:
  - it drives `fpdPulse`, `fpdHalf` and `ratioErr` to 0;
  - it restores the default ratio of 56;
  - the first pulse follows after 56 edges counted from the last edge with reset high.
- R9: Without a further load, the ratio persists, and successive periods keep the same length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast divider clock |
| rst | input | 1 | Synchronous reset, active high |
| ratioWord | input | 15 | Division ratio: swallow count in [2:0], main count in [14:3] |
| ratioLoad | input | 1 | Captures `ratioWord` on the rising clock edge |
| fpdPulse | output | 1 | One-clock pulse per division period |
| fpdHalf | output | 1 | Square wave toggling once per division period |
| ratioErr | output | 1 | Set when the last loaded word was below the minimum ratio |

## Verification
The bench targets several corner cases, and each has a distinct failure signature:
- **Smallest ratios (56, 57, 63, 64, 71).** Here the swallow count is at its extremes and the main count barely exceeds it. A prescaler that picks its modulus one cycle late gives a period that is off by one or by eight.
- **Words below the minimum.** A missing clamp would make the main counter smaller than the swallow count, which wraps the counter into an enormous period.
- **A strobe in the middle of a period.** An unguarded reload would truncate that period.
- **Two strobes inside one period.** The bench checks that the later word wins.
- **Reset in the middle of a run at the largest ratio.** This must fall straight back to the default period.
- **Pulse width and half-rate output.** A pulse stretched over two clocks, or a half-rate output that toggles off-beat, is caught on every sample.

// File: rtl/psd_pkg.sv
package psd_pkg;

  // Strobes that the counting control hands to the ratio/output datapath.
  typedef struct packed {
    logic cycleEnd;   // last input clock of the current output period
  } psdStrobe_t;

endpackage

// File: rtl/psd_ctrl.sv
module psd_ctrl
  import psd_pkg::*;
#(
  parameter int RW        = 15,
  parameter int AW        = 3,
  parameter int DEF_RATIO = 56
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] nextRatio,
  output psdStrobe_t    strobes
);

  localparam int MW = RW - AW;
  localparam logic [AW:0]   MOD_LONG  = (AW+1)'(2**AW);       // reload for /(2^AW+1)
  localparam logic [AW:0]   MOD_SHORT = (AW+1)'(2**AW - 1);   // reload for /2^AW
  localparam logic [RW-1:0] DEF_W     = RW'(DEF_RATIO);

  logic [AW:0]   prescCnt;
  logic [AW-1:0] aLeft;
  logic [MW-1:0] mLeft;
  logic          prescTick;
  logic          cycleEnd;
  logic [RW-1:0] srcRatio;
  logic [AW-1:0] srcA;
  logic [MW-1:0] srcM;

  always_comb begin
    prescTick = (prescCnt == '0);
    cycleEnd  = prescTick && (mLeft == MW'(1));
    srcRatio  = rst ? DEF_W : nextRatio;
    srcA      = srcRatio[AW-1:0];
    srcM      = srcRatio[RW-1:AW];
    strobes.cycleEnd = cycleEnd;
  end

  always_ff @(posedge clk) begin
    if (rst || cycleEnd) begin
      aLeft    <= srcA;
      mLeft    <= srcM;
      prescCnt <= (srcA != '0) ? MOD_LONG : MOD_SHORT;
    end else if (prescTick) begin
      if (aLeft != '0) aLeft <= aLeft - AW'(1);
      mLeft    <= mLeft - MW'(1);
      prescCnt <= (aLeft > AW'(1)) ? MOD_LONG : MOD_SHORT;
    end else begin
      prescCnt <= prescCnt - (AW+1)'(1);
    end
  end

  AST_MAIN_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
    mLeft != '0);  // R1

  AST_END_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    cycleEnd |=> !cycleEnd);  // R6

  AST_PRESC_BOUND: assert property (@(posedge clk) disable iff (rst)
    prescCnt <= MOD_LONG);  // R1

endmodule

// File: rtl/psd_datapath.sv
module psd_datapath
  import psd_pkg::*;
#(
  parameter int RW        = 15,
  parameter int AW        = 3,
  parameter int DEF_RATIO = 56
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] ratioWord,
  input  logic          ratioLoad,
  input  psdStrobe_t    strobes,
  output logic [RW-1:0] nextRatio,
  output logic          fpdPulse,
  output logic          fpdHalf,
  output logic          ratioErr
);

  localparam int MIN_RATIO = (2**AW) * (2**AW - 1);
  localparam logic [RW-1:0] MIN_W = RW'(MIN_RATIO);
  localparam logic [RW-1:0] DEF_W = RW'(DEF_RATIO);

  logic [RW-1:0] heldRatio;
  logic [RW-1:0] clampedWord;
  logic          wordLow;

  always_comb begin
    wordLow     = (ratioWord < MIN_W);
    clampedWord = wordLow ? MIN_W : ratioWord;
    nextRatio   = heldRatio;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      heldRatio <= DEF_W;
      ratioErr  <= 1'b0;
      fpdPulse  <= 1'b0;
      fpdHalf   <= 1'b0;
    end else begin
      if (ratioLoad) begin
        heldRatio <= clampedWord;
        ratioErr  <= wordLow;
      end
      fpdPulse <= strobes.cycleEnd;
      fpdHalf  <= fpdHalf ^ strobes.cycleEnd;
    end
  end

  AST_HELD_LEGAL: assert property (@(posedge clk) disable iff (rst)
    heldRatio >= MIN_W);  // R2

  AST_ERR_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    !ratioLoad |=> $stable(ratioErr));  // R3

  AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    fpdPulse |=> !fpdPulse);  // R6

  AST_HALF_ON_PULSE: assert property (@(posedge clk) disable iff (rst)
    fpdPulse |-> (fpdHalf != $past(fpdHalf)));  // R7

  AST_HALF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !fpdPulse |-> $stable(fpdHalf));  // R7

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import psd_pkg::*;
#(
  parameter int RW        = 15,
  parameter int AW        = 3,
  parameter int DEF_RATIO = 56
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] ratioWord,
  input  logic          ratioLoad,
  output logic          fpdPulse,
  output logic          fpdHalf,
  output logic          ratioErr
);

  localparam int MIN_RATIO = (2**AW) * (2**AW - 1);
  localparam int DEF_SAFE  = (DEF_RATIO < MIN_RATIO) ? MIN_RATIO : DEF_RATIO;

  psdStrobe_t    strobes;
  logic [RW-1:0] nextRatio;

  psd_ctrl #(.RW(RW), .AW(AW), .DEF_RATIO(DEF_SAFE)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .nextRatio (nextRatio),
    .strobes   (strobes)
  );

  psd_datapath #(.RW(RW), .AW(AW), .DEF_RATIO(DEF_SAFE)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ratioWord (ratioWord),
    .ratioLoad (ratioLoad),
    .strobes   (strobes),
    .nextRatio (nextRatio),
    .fpdPulse  (fpdPulse),
    .fpdHalf   (fpdHalf),
    .ratioErr  (ratioErr)
  );

endmodule

// File: tb/tb_pulse_swallow_div.sv
`timescale 1ns/1ps
module tb_pulse_swallow_div;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] ratioWord = '0;
  logic        ratioLoad = 1'b0;
  logic        fpdPulse, fpdHalf, ratioErr;

  pulse_swallow_div dut (
    .clk(clk), .rst(rst), .ratioWord(ratioWord), .ratioLoad(ratioLoad),
    .fpdPulse(fpdPulse), .fpdHalf(fpdHalf), .ratioErr(ratioErr)
  );

  always #5 clk = ~clk;

  int nChk = 0;
  int nFail = 0;
  int edgeCnt = 0;
  int lastGap = 0;
  int pulseNo = 0;
  int widthBad = 0;
  int halfBad = 0;
  int cyc = 0;
  logic prevFpd = 1'b0;
  logic prevHalf = 1'b0;
  bit   done = 0;

  localparam int NV = 11;
  localparam int VWORD [NV] = '{56, 57, 63, 64, 71, 0, 55, 100, 1023, 5000, 32767};
  localparam int VEXP  [NV] = '{56, 57, 63, 64, 71, 56, 56, 100, 1023, 5000, 32767};
  localparam int VERR  [NV] = '{0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0};

  // Monitor: samples 3 ns after each rising edge.
  always @(posedge clk) begin
    #3;
    if (rst) begin
      edgeCnt  = 0;
      prevFpd  = fpdPulse;
      prevHalf = fpdHalf;
    end else begin
      edgeCnt++;
      if (fpdPulse && prevFpd) widthBad++;
      if (fpdPulse ? (fpdHalf == prevHalf) : (fpdHalf != prevHalf)) halfBad++;
      if (fpdPulse) begin
        lastGap = edgeCnt;
        edgeCnt = 0;
        pulseNo++;
      end
      prevFpd  = fpdPulse;
      prevHalf = fpdHalf;
    end
  end

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=<180000", cyc);
      finishRun();
    end
  end

  task automatic waitPulse();
    int p = pulseNo;
    while (pulseNo == p) @(negedge clk);
  endtask

  task automatic loadWord(int w);
    @(negedge clk);
    ratioWord = 15'(w);
    ratioLoad = 1'b1;
    @(negedge clk);
    ratioLoad = 1'b0;
  endtask

  // Load just after a pulse, then check the old and the new periods.
  task automatic applyVec(int w, int expN, int expErr, int oldN, bit rep);
    waitPulse();
    loadWord(w);
    waitPulse();
    chk("R4 running period keeps old ratio", lastGap, oldN);
    chk("R2 error flag after load", int'(ratioErr), expErr);
    waitPulse();
    chk("R1 period equals 8M+A", lastGap, expN);
    if (rep) begin
      waitPulse();
      chk("R9 ratio persists", lastGap, expN);
      chk("R3 flag unchanged without load", int'(ratioErr), expErr);
    end
  endtask

  initial begin
    int oldN;
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    chk("R8 pulse low in reset", int'(fpdPulse), 0);
    chk("R8 half low in reset", int'(fpdHalf), 0);
    chk("R8 err low in reset", int'(ratioErr), 0);
    rst = 1'b0;
    waitPulse();
    chk("R8 first pulse after default 56", lastGap, 56);

    oldN = 56;
    for (int i = 0; i < NV; i++) begin
      applyVec(VWORD[i], VEXP[i], VERR[i], oldN, i < NV - 1);
      oldN = VEXP[i];
    end

    // R8: reset in the middle of the largest ratio
    repeat (100) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 pulse low after reset", int'(fpdPulse), 0);
    chk("R8 half low after reset", int'(fpdHalf), 0);
    rst = 1'b0;
    waitPulse();
    chk("R8 default period after reset", lastGap, 56);

    // R1: pseudo-random legal words
    lfsr = 16'hACE1;
    oldN = 56;
    for (int k = 0; k < 4; k++) begin
      int w;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      w = 56 + int'(lfsr) % 1500;
      applyVec(w, 8 * (w >> 3) + (w & 7), 0, oldN, 1'b0);
      oldN = w;
    end

    // R5: two loads within one period, the later one wins
    waitPulse();
    loadWord(300);
    loadWord(77);
    waitPulse();
    chk("R5 period of double load unchanged", lastGap, oldN);
    waitPulse();
    chk("R5 last load wins", lastGap, 77);

    // R3: error flag holds across periods and clears only on a legal load
    loadWord(9);
    waitPulse();
    waitPulse();
    waitPulse();
    chk("R3 error flag held", int'(ratioErr), 1);
    chk("R2 clamped period", lastGap, 56);
    loadWord(200);
    chk("R2 error cleared by legal load", int'(ratioErr), 0);

    repeat (5) @(negedge clk);
    chk("R6 pulse width violations", widthBad, 0);
    chk("R7 half-rate output violations", halfBad, 0);
    finishRun();
  end

endmodule